// File: doc/BRIEF.md
# Interleaved Block-Fill Memory Controller

This block returns cache block fills from a memory split into `NBANK` banks behind a one-word data bus. Word addresses are spread across the banks so that neighbouring words sit in different banks. When a fill is requested, the controller spends one cycle presenting the address. In interleaved mode it then starts every bank the block touches in the same cycle. After one bank access latency the words stream back on consecutive cycles. With the default latency of 25 cycles, a four-word fill takes 30 cycles.

A mode input selects a sequential comparison mode instead. There, each word gets its own address cycle, bank access and transfer cycle before the next word begins, so the same four-word fill takes 108 cycles. Only one request is in flight at a time. `busy` stays high until the last word has been handed over, and requests seen while `busy` is high are dropped. The banks are fixed-latency models. Each bank keeps one quarter of the word space (for four banks) and returns a computed word pattern, so no content needs loading.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `rd_valid` and `rd_done` are 0.
- R2: A request is accepted at a rising edge where `req_valid` is 1, `busy` is 0 and `req_len` lies in 1..NBANK. `busy` reads 1 from the cycle after that edge.
- R3: A request with `req_len` of 0 or greater than NBANK is dropped. `busy` and `rd_valid` stay 0.
- R4: Word address a lives in bank a mod NBANK at row a / NBANK. Its data is the low WORD_W bits of (a × 0x9E3779B1 + 0x1234) mod 2^32.
- R5: In interleaved mode (`mode_seq`=0 at acceptance), with acceptance at edge t0, word k is presented in the cycle after edge t0+LAT+1+k. A block of n words ends in cycle LAT+1+n counted from acceptance: 30 cycles for 4 words and 28 cycles for 2 words at LAT=25.
- R6: In sequential mode (`mode_seq`=1 at acceptance), word k is presented in the cycle after edge t0+LAT+1+k×(LAT+2). At most one bank access is started per cycle. A 4-word block ends in cycle 108 at LAT=25.
- R7: Words arrive in ascending address order with `rd_idx` = k. The address of word k is (req_addr+k) mod 2^ADDR_W.
- R8: `rd_done` is 1 for exactly one cycle, together with the final word of the block, and at no other time.
- R9: `busy` stays 1 through the cycle of the final word and is 0 in the following cycle. Requests arriving while `busy` is 1 are dropped.
- R10: `mode_seq` is sampled only at acceptance. Changing it during a block does not alter that block's timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Block fill request strobe |
| req_addr | input | ADDR_W | Word address of the first word of the block |
| req_len | input | clog2(NBANK)+1 | Number of words, 1..NBANK |
| mode_seq | input | 1 | 1 = sequential comparison mode, 0 = interleaved |
| busy | output | 1 | A block is in progress; new requests are dropped |
| rd_valid | output | 1 | A data word is on `rd_data` this cycle |
| rd_data | output | WORD_W | Returned data word |
| rd_idx | output | clog2(NBANK) | Position of the word within the block |
| rd_done | output | 1 | Final word of the block |

## Verification
A behavioural model in the bench schedules each expected word from the acceptance edge, and the outputs are compared against it every cycle.

Fills are tried in several forms:
- aligned and unaligned starts, lengths of 1 to 4, and a block that wraps past the top of the address space, which separate a correct bank/row mapping from one that only works at bank 0;
- the same lengths in sequential mode, where the measured completion cycle (108 against 30, 54 against 28) shows whether the bank accesses truly overlap.

Requests are also sent with out-of-range lengths, while `busy` is high, held continuously across blocks, and with the mode flipped mid-block. These check how acceptance is gated.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_HOLD
  } ilv_state_e;

  // Content model of the whole word space: low 32 bits are the data pattern.
  function automatic logic [63:0] fill_word(input logic [31:0] a);
    logic [31:0] lo;
    lo = a * 32'h9E37_79B1 + 32'h0000_1234;
    return {a ^ 32'hA5A5_0000, lo};
  endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int WORD_W  = 32,
  parameter int NBANK   = 4,
  parameter int LAT     = 25,
  parameter int ROW_W   = 8,
  parameter int BANK_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ROW_W-1:0]  row,
  output logic              ready,
  output logic [WORD_W-1:0] data
);
  localparam int BANK_W = $clog2(NBANK);
  localparam int CNT_W  = $clog2(LAT + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic              armed_q;
  logic [WORD_W-1:0] data_q;
  logic [31:0]       full_addr;
  logic [63:0]       pat;

  assign full_addr = 32'({row, BANK_W'(BANK_ID)});
  assign pat       = ilv_pkg::fill_word(full_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      data_q  <= '0;
    end else if (start) begin
      cnt_q   <= CNT_W'(LAT - 1);
      armed_q <= 1'b1;
      data_q  <= pat[WORD_W-1:0];
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ready = armed_q && (cnt_q == '0);
  assign data  = data_q;

endmodule

// File: rtl/ilv_ctrl.sv
module ilv_ctrl #(
  parameter int WORD_W = 32,
  parameter int NBANK  = 4,
  parameter int ADDR_W = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [$clog2(NBANK):0]        req_len,
  input  logic                          mode_seq,
  output logic [NBANK-1:0]              bank_start,
  output logic [NBANK-1:0][ADDR_W-$clog2(NBANK)-1:0] bank_row,
  input  logic [NBANK-1:0]              bank_ready,
  input  logic [NBANK-1:0][WORD_W-1:0]  bank_data,
  output logic                          busy,
  output logic                          rd_valid,
  output logic [WORD_W-1:0]             rd_data,
  output logic [$clog2(NBANK)-1:0]      rd_idx,
  output logic                          rd_done,
  output logic                          blk_seq
);
  import ilv_pkg::*;

  localparam int BANK_W = $clog2(NBANK);
  localparam int LEN_W  = BANK_W + 1;

  ilv_state_e        st_q;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  idx_q;
  logic              seq_q;
  logic              vld_q;
  logic              done_q;
  logic [WORD_W-1:0] data_q;
  logic [BANK_W-1:0] ridx_q;

  function automatic logic len_ok(input logic [LEN_W-1:0] l);
    return (l != '0) && (l <= LEN_W'(NBANK));
  endfunction

  // Named events for the checker and for readability.
  logic              accept;
  logic              take;
  logic              last_word;
  logic [ADDR_W-1:0] cur_addr;
  logic [BANK_W-1:0] cur_bank;

  assign busy      = (st_q != ST_IDLE) || vld_q;
  assign accept    = !busy && req_valid && len_ok(req_len);
  assign cur_addr  = base_q + ADDR_W'(idx_q);
  assign cur_bank  = cur_addr[BANK_W-1:0];
  assign take      = (st_q == ST_WAIT) && bank_ready[cur_bank];
  assign last_word = (idx_q == len_q - 1'b1);

  for (genvar b = 0; b < NBANK; b++) begin : g_sel
    logic [BANK_W-1:0] ofs;
    logic [ADDR_W-1:0] baddr;
    assign ofs           = BANK_W'(b) - base_q[BANK_W-1:0];
    assign baddr         = base_q + ADDR_W'(ofs);
    assign bank_start[b] = (st_q == ST_ADDR) &&
                           (seq_q ? (ofs == idx_q[BANK_W-1:0]) : (LEN_W'(ofs) < len_q));
    assign bank_row[b]   = baddr[ADDR_W-1:BANK_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      base_q <= '0;
      len_q  <= '0;
      idx_q  <= '0;
      seq_q  <= 1'b0;
      vld_q  <= 1'b0;
      done_q <= 1'b0;
      data_q <= '0;
      ridx_q <= '0;
    end else begin
      vld_q  <= 1'b0;
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept) begin
          base_q <= req_addr;
          len_q  <= req_len;
          seq_q  <= mode_seq;
          idx_q  <= '0;
          st_q   <= ST_ADDR;
        end
        ST_ADDR: st_q <= ST_WAIT;
        ST_WAIT: if (take) begin
          vld_q  <= 1'b1;
          data_q <= bank_data[cur_bank];
          ridx_q <= idx_q[BANK_W-1:0];
          done_q <= last_word;
          if (last_word) begin
            st_q <= ST_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= seq_q ? ST_HOLD : ST_WAIT;
          end
        end
        ST_HOLD: st_q <= ST_ADDR;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_valid = vld_q;
  assign rd_data  = data_q;
  assign rd_idx   = ridx_q;
  assign rd_done  = done_q;
  assign blk_seq  = seq_q;

endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl #(
  parameter int WORD_W = 32,
  parameter int NBANK  = 4,
  parameter int LAT    = 25,
  parameter int ADDR_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [$clog2(NBANK):0]   req_len,
  input  logic                     mode_seq,
  output logic                     busy,
  output logic                     rd_valid,
  output logic [WORD_W-1:0]        rd_data,
  output logic [$clog2(NBANK)-1:0] rd_idx,
  output logic                     rd_done
);
  localparam int BANK_W = $clog2(NBANK);
  localparam int ROW_W  = ADDR_W - BANK_W;

  logic [NBANK-1:0]             bank_start;
  logic [NBANK-1:0][ROW_W-1:0]  bank_row;
  logic [NBANK-1:0]             bank_ready;
  logic [NBANK-1:0][WORD_W-1:0] bank_data;
  logic                         blk_seq;

  ilv_ctrl #(
    .WORD_W(WORD_W), .NBANK(NBANK), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len), .mode_seq(mode_seq),
    .bank_start(bank_start), .bank_row(bank_row),
    .bank_ready(bank_ready), .bank_data(bank_data),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_idx(rd_idx), .rd_done(rd_done), .blk_seq(blk_seq)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    ilv_bank #(
      .WORD_W(WORD_W), .NBANK(NBANK), .LAT(LAT), .ROW_W(ROW_W), .BANK_ID(b)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .start(bank_start[b]), .row(bank_row[b]),
      .ready(bank_ready[b]), .data(bank_data[b])
    );
  end

endmodule

// File: rtl/ilv_mem_ctrl_chk.sv
module ilv_mem_ctrl_chk #(
  parameter int NBANK = 4,
  parameter int LAT   = 25
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     busy,
  input logic                     rd_valid,
  input logic                     rd_done,
  input logic [$clog2(NBANK)-1:0] rd_idx,
  input logic                     blk_seq,
  input logic [NBANK-1:0]         bank_start,
  input logic [NBANK-1:0]         bank_ready
);
  localparam int CW = $clog2(LAT + 1);

  // R8
  done_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> rd_valid);

  // R9
  busy_covers_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);

  // R9
  release_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !busy);

  // R7
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_done && !blk_seq) |=> (rd_valid && (rd_idx == $past(rd_idx) + 1'b1)));

  // R6
  seq_one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_seq |-> $onehot0(bank_start));

  for (genvar b = 0; b < NBANK; b++) begin : g_lat
    logic [CW-1:0] since_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  since_q <= CW'(LAT);
      else if (bank_start[b])      since_q <= '0;
      else if (since_q < CW'(LAT)) since_q <= since_q + 1'b1;
    end
    // R5
    bank_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_ready[b] |-> (since_q >= CW'(LAT - 1)));
  end

endmodule

bind ilv_mem_ctrl ilv_mem_ctrl_chk #(.NBANK(NBANK), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_valid(rd_valid), .rd_done(rd_done),
  .rd_idx(rd_idx), .blk_seq(blk_seq), .bank_start(bank_start), .bank_ready(bank_ready)
);

// File: tb/sim_ilv_mem_ctrl.sv
`timescale 1ns/1ps
module sim_ilv_mem_ctrl;
  localparam int WW = 32;
  localparam int NB = 4;
  localparam int LT = 25;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [2:0]    req_len = '0;
  logic          mode_seq = 1'b0;
  logic          busy, rd_valid, rd_done;
  logic [WW-1:0] rd_data;
  logic [1:0]    rd_idx;

  always #2.5 clk = ~clk;

  ilv_mem_ctrl #(.WORD_W(WW), .NBANK(NB), .LAT(LT), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .mode_seq(mode_seq), .busy(busy), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_idx(rd_idx), .rd_done(rd_done)
  );

  typedef struct { int at; int addr; int idx; bit last; } ev_t;

  int    vectors = 0;
  int    fails = 0;
  string tag = "R1";
  int    cyc = 0;
  int    acc_cyc = 0;
  int    meas_lat = -1;
  ev_t   q[$];
  ev_t   ev;
  bit    exp_valid = 0, exp_done = 0, exp_busy = 0;
  logic [31:0] exp_data = '0;
  int    exp_idx = 0;

  function automatic logic [31:0] ref_fill(input int a);
    logic [31:0] x;
    x = a;
    return x * 32'h9E37_79B1 + 32'h0000_1234;
  endfunction

  // Behavioural reference: a schedule of future words per accepted request.
  always @(posedge clk or negedge rst_n) begin
    bit acc;
    int step;
    if (!rst_n) begin
      cyc = 0;
      q.delete();
      exp_valid = 0; exp_done = 0; exp_busy = 0;
    end else begin
      cyc++;
      acc = req_valid && !exp_busy && (req_len >= 1) && (req_len <= NB);
      exp_valid = 0; exp_done = 0;
      if (q.size() > 0 && q[0].at == cyc) begin
        ev = q.pop_front();
        exp_valid = 1; exp_done = ev.last;
        exp_data = ref_fill(ev.addr); exp_idx = ev.idx;
      end
      if (acc) begin
        acc_cyc = cyc;
        step = mode_seq ? (LT + 2) : 1;
        for (int k = 0; k < int'(req_len); k++)
          q.push_back('{cyc + LT + 1 + k * step, (int'(req_addr) + k) % (1 << AW), k, k == int'(req_len) - 1});
      end
      exp_busy = (q.size() != 0) || exp_valid;
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      bit bad;
      vectors++;
      bad = (busy !== exp_busy) || (rd_valid !== exp_valid) || (rd_done !== exp_done);
      if (exp_valid && ((rd_data !== exp_data) || (int'(rd_idx) != exp_idx))) bad = 1;
      if (bad) begin
        fails++;
        $display("FAIL %s cyc=%0d busy %b/%b valid %b/%b done %b/%b idx %0d/%0d data %h/%h (act/exp)",
                 tag, cyc, busy, exp_busy, rd_valid, exp_valid, rd_done, exp_done,
                 rd_idx, exp_idx, rd_data, exp_data);
      end
      if (rd_done === 1'b1) meas_lat = cyc - acc_cyc + 1;
    end
  end

  task automatic summary_and_end();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic issue(input int a, input int l, input bit m);
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(a); req_len = 3'(l); mode_seq = m;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (exp_busy || q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_lat(input int want);
    vectors++;
    if (meas_lat != want) begin
      fails++;
      $display("FAIL %s block length in cycles act=%0d exp=%0d", tag, meas_lat, want);
    end
    meas_lat = -1;
  endtask

  task automatic chk_quiet(input string t);
    vectors++;
    if (busy !== 1'b0 || rd_valid !== 1'b0 || rd_done !== 1'b0) begin
      fails++;
      $display("FAIL %s busy/valid/done act=%b%b%b exp=000", t, busy, rd_valid, rd_done);
    end
  endtask

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog expired, tag %s act=running exp=finished", tag);
    summary_and_end();
  end

  initial begin
    // R1: outputs quiet in reset and right after it
    repeat (3) @(negedge clk);
    chk_quiet("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_quiet("R1");
    repeat (2) @(negedge clk);

    // R2: busy visible in the cycle after acceptance
    tag = "R2";
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(40); req_len = 3'd1; mode_seq = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    vectors++;
    if (busy !== 1'b1) begin
      fails++;
      $display("FAIL R2 busy after accept act=%b exp=1", busy);
    end
    wait_idle();

    // R5: interleaved timing, 30 / 28 / 27 cycles
    tag = "R5";
    issue(0, 4, 0); wait_idle(); chk_lat(30);
    issue(6, 2, 0); wait_idle(); chk_lat(28);
    issue(9, 1, 0); wait_idle(); chk_lat(27);

    // R4: bank/row mapping and data on rows away from zero
    tag = "R4";
    issue(513, 4, 0); wait_idle();
    issue(770, 3, 0); wait_idle();

    // R7: unaligned start and address wrap
    tag = "R7";
    issue(5, 3, 0); wait_idle();
    issue(1022, 4, 0); wait_idle(); chk_lat(30);

    // R6: sequential timing, 108 / 54 cycles
    tag = "R6";
    issue(12, 4, 1); wait_idle(); chk_lat(108);
    issue(3, 2, 1); wait_idle(); chk_lat(54);

    // R8: done with final word of a 3-word sequential block
    tag = "R8";
    issue(70, 3, 1); wait_idle(); chk_lat(81);

    // R3: out-of-range lengths are dropped
    tag = "R3";
    issue(8, 0, 0); @(negedge clk); chk_quiet("R3");
    issue(8, 5, 0); @(negedge clk); chk_quiet("R3");
    issue(8, 7, 1); @(negedge clk); chk_quiet("R3");

    // R9: request while busy is dropped; held request accepted when free
    tag = "R9";
    issue(20, 4, 0);
    repeat (5) @(negedge clk);
    issue(44, 4, 1);
    wait_idle(); chk_quiet("R9");
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(100); req_len = 3'd4; mode_seq = 1'b0;
    repeat (70) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();

    // R10: mode change during a block has no effect on it
    tag = "R10";
    issue(60, 4, 0);
    repeat (3) @(negedge clk);
    mode_seq = 1'b1;
    wait_idle(); chk_lat(30);
    mode_seq = 1'b0;

    summary_and_end();
  end

endmodule